// File: doc/BRIEF.md
# Vectored Interrupt Mapping and Dispatch Controller

This block gathers 64 level-sensitive interrupt sources and turns them into a single vectored request. The first 32 sources come from PCI slots and are enabled in groups of four, with one mapping register per group. The remaining 32 come from on-board peripherals, and each of them has its own mapping register. Each mapping register carries an enable (valid) flag in bit 31. Its lower bits hold a fixed routing code that software can read but cannot change.

Only one request is outstanding at any time. It appears as a single set bit on a 64-bit vector output and stays there until software retires it. Software retires it by writing the matching clear register or by dropping the valid flag of the mapping entry that covers it. After each retirement the controller scans again, picking the lowest-numbered source that is pending and enabled. In that scan every PCI source ranks ahead of every on-board source. Software reaches all of these registers through a plain 32-bit read/write port with a 16-bit byte offset.

Top module: `irq_route_ctrl`

## Requirements
- R1: A source can be selected only while the valid flag (bit 31) of its mapping entry is set. PCI source n uses group entry n/4 and on-board source 32+k uses on-board entry k.
- R2: A write to the upper word of a mapping entry changes only bit 31. A read of the upper word returns {valid, routing code}. The routing code is 0x7C0 | (4*g) for PCI group g and 0x7E0 + k for on-board entry k.
- R3: While idle, the controller selects the lowest-numbered source that is pending and enabled, so sources 0..31 always come before 32..63. A source that rises at clock edge t can be presented after edge t+1.
- R4: While a request is outstanding, no new selection is made and the vector output holds its value, whatever the inputs or other register writes do.
- R5: A mapping write that clears the valid flag of the entry covering the outstanding request retires that request, and a rescan follows on the same edge. Disabling any other entry leaves the request in place.
- R6: A write to a PCI clear register at 0x1400 + 32*g + 4 retires the outstanding request only if that request is a PCI source with number/4 == g. A rescan follows on the same edge, and it may select the same source again.
- R7: A write to an on-board clear register at 0x1800 + 8*k + 4 retires the outstanding request only if that request is 32+k. A rescan follows on the same edge.
- R8: The vector output is one-hot with bit n set while request n is outstanding, and it is all zeros while idle.
- R9: Reset clears every valid flag, the pending state and the outstanding request, and leaves the routing codes at their fixed values.
- R10: PCI mapping entries sit at 0xC00 + 8*g + 4 and on-board mapping entries at 0x1000 + 8*k + 4. Reads of lower words, of clear registers and of unmapped offsets return zero, and writes to lower words or unmapped offsets have no effect.
- R11: Deasserting an input removes it from the pending set but does not retire a request that has already been issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Level interrupt sources; 0..31 PCI, 32..63 on-board |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| vec_out | output | 64 | One-hot outstanding request, zero when idle |

## Verification
The bench builds the controller with its default values of eight PCI groups and thirty-two on-board entries. With these values every mapping and clear offset in the register map exists, and both priority regions are fully populated. It can therefore test the boundary between the last PCI group and the first on-board entry, the lowest slot of the map and the highest. Random traffic spread over all four register pages, together with random input patterns, is compared cycle by cycle against a reference model in the bench.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Register pages (addr[15:8]) of the four active windows.
  localparam logic [7:0] PG_PMAP = 8'h0C;
  localparam logic [7:0] PG_BMAP = 8'h10;
  localparam logic [7:0] PG_PCLR = 8'h14;
  localparam logic [7:0] PG_BCLR = 8'h18;

  // PCI sources that share one mapping entry.
  localparam int GRP_SZ = 4;
  localparam int GRP_SH = $clog2(GRP_SZ);

  // Fixed routing code held in the low 31 bits of a PCI group entry.
  function automatic logic [30:0] pci_route_code(int unsigned g);
    return 31'(32'h7C0 | (g << GRP_SH));
  endfunction

  // Fixed routing code held in the low 31 bits of an on-board entry.
  function automatic logic [30:0] brd_route_code(int unsigned k);
    return 31'(32'h7E0 + k);
  endfunction
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_route_pkg::*;
#(
  parameter int N_GRP = 8,
  parameter int N_BRD = 32,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int N_PCI = N_GRP * GRP_SZ,
  localparam int N_IN  = N_PCI + N_BRD,
  localparam int PG_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int BR_W  = (N_BRD > 1) ? $clog2(N_BRD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [N_IN-1:0] en_next,
  output logic [N_IN-1:0] en_q,
  output logic            pmap_wr,
  output logic            bmap_wr,
  output logic            pclr_wr,
  output logic            bclr_wr,
  output logic [PG_W-1:0] pmap_idx,
  output logic [BR_W-1:0] bmap_idx,
  output logic [PG_W-1:0] pclr_idx,
  output logic [BR_W-1:0] bclr_idx
);
  logic [7:0] page, off;
  logic pmap_sel, bmap_sel, pclr_sel, bclr_sel;
  logic [N_GRP-1:0] pv_q, pv_d;
  logic [N_BRD-1:0] bv_q, bv_d;
  logic unused_bits;

  assign page = addr[15:8];
  assign off  = addr[7:0];
  assign unused_bits = ^{wdata[DW-2:0], addr[1:0]};

  assign pmap_idx = off[3 +: PG_W];
  assign bmap_idx = off[3 +: BR_W];
  assign pclr_idx = off[5 +: PG_W];
  assign bclr_idx = off[3 +: BR_W];

  assign pmap_sel = (page == PG_PMAP) && off[2] && ({3'b000, off[7:3]} < 8'(N_GRP));
  assign bmap_sel = (page == PG_BMAP) && off[2] && ({3'b000, off[7:3]} < 8'(N_BRD));
  assign pclr_sel = (page == PG_PCLR) && off[2] && ({5'b00000, off[7:5]} < 8'(N_GRP));
  assign bclr_sel = (page == PG_BCLR) && off[2] && ({3'b000, off[7:3]} < 8'(N_BRD));

  assign pmap_wr = wr_en && pmap_sel;
  assign bmap_wr = wr_en && bmap_sel;
  assign pclr_wr = wr_en && pclr_sel;
  assign bclr_wr = wr_en && bclr_sel;

  // Only the valid flag is stored; routing codes are constants.
  always_comb begin
    pv_d = pv_q;
    bv_d = bv_q;
    if (pmap_wr) pv_d[pmap_idx] = wdata[DW-1];
    if (bmap_wr) bv_d[bmap_idx] = wdata[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= '0;
      bv_q <= '0;
    end else begin
      pv_q <= pv_d;
      bv_q <= bv_d;
    end
  end

  // Expand entry flags to per-source enables.
  for (genvar s = 0; s < N_PCI; s++) begin : g_pci_en
    assign en_next[s] = pv_d[s / GRP_SZ];
    assign en_q[s]    = pv_q[s / GRP_SZ];
  end
  for (genvar k = 0; k < N_BRD; k++) begin : g_brd_en
    assign en_next[N_PCI + k] = bv_d[k];
    assign en_q[N_PCI + k]    = bv_q[k];
  end

  always_comb begin
    rdata = '0;
    if (pmap_sel)
      rdata = DW'({pv_q[pmap_idx], pci_route_code(32'(pmap_idx))});
    else if (bmap_sel)
      rdata = DW'({bv_q[bmap_idx], brd_route_code(32'(bmap_idx))});
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IN = 64,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] cand,
  output logic            found,
  output logic [IW-1:0]   idx
);
  // Lowest index wins: walk downward so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold
  import irq_route_pkg::*;
#(
  parameter int N_GRP = 8,
  parameter int N_BRD = 32,
  localparam int N_PCI = N_GRP * GRP_SZ,
  localparam int N_IN  = N_PCI + N_BRD,
  localparam int IW    = $clog2(N_IN),
  localparam int PG_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int BR_W  = (N_BRD > 1) ? $clog2(N_BRD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pmap_wr,
  input  logic            bmap_wr,
  input  logic            pclr_wr,
  input  logic            bclr_wr,
  input  logic            wr_valid,
  input  logic [PG_W-1:0] pmap_idx,
  input  logic [BR_W-1:0] bmap_idx,
  input  logic [PG_W-1:0] pclr_idx,
  input  logic [BR_W-1:0] bclr_idx,
  input  logic            found,
  input  logic [IW-1:0]   pick_idx,
  output logic            busy,
  output logic            retire,
  output logic            take,
  output logic [N_IN-1:0] vec_out
);
  logic [IW-1:0] cur;
  logic is_pci;
  logic [IW-1:0] grp, bidx;
  logic hit_pmap, hit_bmap, hit_pclr, hit_bclr;

  assign is_pci = cur < IW'(N_PCI);
  assign grp    = cur >> GRP_SH;
  assign bidx   = cur - IW'(N_PCI);

  assign hit_pmap = pmap_wr && !wr_valid && is_pci  && (grp  == IW'(pmap_idx));
  assign hit_bmap = bmap_wr && !wr_valid && !is_pci && (bidx == IW'(bmap_idx));
  assign hit_pclr = pclr_wr && is_pci  && (grp  == IW'(pclr_idx));
  assign hit_bclr = bclr_wr && !is_pci && (bidx == IW'(bclr_idx));

  assign retire = busy && (hit_pmap || hit_bmap || hit_pclr || hit_bclr);
  assign take   = (!busy || retire) && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (!busy || retire) begin
      busy <= found;
      if (found) cur <= pick_idx;
    end
  end

  assign vec_out = busy ? (N_IN'(1) << cur) : '0;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_GRP = 8,
  parameter int N_BRD = 32,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int N_PCI = N_GRP * GRP_SZ,
  localparam int N_IN  = N_PCI + N_BRD,
  localparam int IW    = $clog2(N_IN),
  localparam int PG_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int BR_W  = (N_BRD > 1) ? $clog2(N_BRD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [N_IN-1:0] vec_out
);
  logic [N_IN-1:0] pend_q, en_next, en_q, cand;
  logic pmap_wr, bmap_wr, pclr_wr, bclr_wr;
  logic [PG_W-1:0] pmap_idx, pclr_idx;
  logic [BR_W-1:0] bmap_idx, bclr_idx;
  logic found, busy, retire, take;
  logic [IW-1:0] pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_in;
  end

  irq_map_regs #(.N_GRP(N_GRP), .N_BRD(N_BRD), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en_next(en_next), .en_q(en_q),
    .pmap_wr(pmap_wr), .bmap_wr(bmap_wr), .pclr_wr(pclr_wr), .bclr_wr(bclr_wr),
    .pmap_idx(pmap_idx), .bmap_idx(bmap_idx), .pclr_idx(pclr_idx), .bclr_idx(bclr_idx)
  );

  assign cand = pend_q & en_next;

  irq_pick #(.N_IN(N_IN)) u_pick (.cand(cand), .found(found), .idx(pick_idx));

  irq_hold #(.N_GRP(N_GRP), .N_BRD(N_BRD)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .pmap_wr(pmap_wr), .bmap_wr(bmap_wr), .pclr_wr(pclr_wr), .bclr_wr(bclr_wr),
    .wr_valid(wdata[DW-1]),
    .pmap_idx(pmap_idx), .bmap_idx(bmap_idx), .pclr_idx(pclr_idx), .bclr_idx(bclr_idx),
    .found(found), .pick_idx(pick_idx),
    .busy(busy), .retire(retire), .take(take), .vec_out(vec_out)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N_IN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] vec_out,
  input logic            busy,
  input logic            retire,
  input logic            take,
  input logic [N_IN-1:0] cand,
  input logic [N_IN-1:0] en_q
);
  // R8: at most one request line high
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_out));

  // R4: an outstanding request that is not retired stays unchanged
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !retire) |=> $stable(vec_out));

  // R1: a freshly selected source belongs to an enabled mapping entry
  p_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((vec_out & en_q) != '0));

  // R3: the selected source was a candidate at selection time
  p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (($past(cand) & vec_out) != '0));

  // R3: no lower-numbered candidate was passed over
  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (($past(cand) & (vec_out - N_IN'(1))) == '0));
endmodule

bind irq_route_ctrl irq_route_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_out(vec_out), .busy(busy),
  .retire(retire), .take(take), .cand(cand), .en_q(en_q)
);

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] vec_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .vec_out(vec_out)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_pv;
  logic [31:0] m_bv;
  logic [63:0] m_pend;
  logic        m_busy;
  int          m_cur;
  logic [7:0]  n_pv;
  logic [31:0] n_bv;
  logic        m_ret;

  function automatic bit src_on(int i, logic [7:0] pv, logic [31:0] bv);
    if (i < 32) return pv[i / 4];
    return bv[i - 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pv = '0; m_bv = '0; m_pend = '0; m_busy = 1'b0; m_cur = 0;
    end else begin
      n_pv = m_pv; n_bv = m_bv; m_ret = 1'b0;
      if (wr_en && addr[2]) begin
        case (addr[15:8])
          8'h0C: if (addr[7:6] == 2'b00) begin
            n_pv[addr[5:3]] = wdata[31];
            if (m_busy && m_cur < 32 && (m_cur / 4) == int'(addr[5:3]) && !wdata[31]) m_ret = 1'b1;
          end
          8'h10: begin
            n_bv[addr[7:3]] = wdata[31];
            if (m_busy && m_cur >= 32 && (m_cur - 32) == int'(addr[7:3]) && !wdata[31]) m_ret = 1'b1;
          end
          8'h14: if (m_busy && m_cur < 32 && (m_cur / 4) == int'(addr[7:5])) m_ret = 1'b1;
          8'h18: if (m_busy && m_cur == 32 + int'(addr[7:3])) m_ret = 1'b1;
          default: ;
        endcase
      end
      if (!m_busy || m_ret) begin
        m_busy = 1'b0;
        for (int i = 0; i < 64; i++)
          if (!m_busy && m_pend[i] && src_on(i, n_pv, n_bv)) begin
            m_busy = 1'b1; m_cur = i;
          end
      end
      m_pv = n_pv; m_bv = n_bv;
      m_pend = irq_in;
    end
  end

  function automatic logic [63:0] exp_vec();
    return m_busy ? (64'd1 << m_cur) : 64'd0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    if (!a[2]) return 32'd0;
    if (a[15:8] == 8'h0C && a[7:6] == 2'b00)
      return {m_pv[a[5:3]], 31'(11'h7C0 + 4 * int'(a[5:3]))};
    if (a[15:8] == 8'h10)
      return {m_bv[a[7:3]], 31'(11'h7E0 + int'(a[7:3]))};
    return 32'd0;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd4242);
    idle(2);
    #1 check("R9 vec during reset", vec_out, 64'd0);
    rst_n = 1'b1;
    idle(2);
    check("R9 vec after reset", vec_out, 64'd0);
    rd(16'h0C1C, v); check("R9 pci map 3 code", 64'(v), 64'h7CC);
    rd(16'h102C, v); check("R9 board map 5 code", 64'(v), 64'h7E5);
    rd(16'h10FC, v); check("R2 board map 31 code", 64'(v), 64'h7FF);
    rd(16'h0C18, v); check("R10 lower word reads zero", 64'(v), 64'd0);
    rd(16'h1404, v); check("R10 clear reg reads zero", 64'(v), 64'd0);

    @(negedge clk); irq_in[5] = 1'b1;
    idle(3);
    check("R1 disabled source not presented", vec_out, 64'd0);
    wr(16'h0C0C, 32'h8000_0000);
    check("R3 enabled source presented", vec_out, 64'd1 << 5);
    rd(16'h0C0C, v); check("R2 valid readback", 64'(v), 64'h8000_07C4);
    wr(16'h0C0C, 32'h8000_0FFF);
    rd(16'h0C0C, v); check("R2 code bits not writable", 64'(v), 64'h8000_07C4);

    @(negedge clk); irq_in[40] = 1'b1; irq_in[2] = 1'b1;
    wr(16'h1044, 32'h8000_0000);
    wr(16'h0C04, 32'h8000_0000);
    check("R4 lower source waits", vec_out, 64'd1 << 5);
    wr(16'h1464, 32'h0);
    check("R6 wrong group clear ignored", vec_out, 64'd1 << 5);
    wr(16'h182C, 32'h0);
    check("R7 board clear on PCI request ignored", vec_out, 64'd1 << 5);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(3);
    check("R11 deassert keeps request", vec_out, 64'd1 << 5);
    wr(16'h1424, 32'h0);
    check("R6 group clear then rescan", vec_out, 64'd1 << 2);
    wr(16'h1404, 32'h0);
    check("R6 still pending source reselected", vec_out, 64'd1 << 2);
    @(negedge clk); irq_in[2] = 1'b0;
    idle(2);
    wr(16'h1404, 32'h0);
    check("R3 board source after PCI drained", vec_out, 64'd1 << 40);
    wr(16'h1844, 32'h0);
    check("R7 board clear rescan", vec_out, 64'd1 << 40);
    @(negedge clk); irq_in[33] = 1'b1;
    wr(16'h100C, 32'h8000_0000);
    check("R4 hold with new enabled source", vec_out, 64'd1 << 40);
    wr(16'h0C04, 32'h0);
    check("R5 other entry disable keeps request", vec_out, 64'd1 << 40);
    wr(16'h1044, 32'h0);
    check("R5 disable retires and rescans", vec_out, 64'd1 << 33);
    rd(16'h1044, v); check("R2 disabled readback", 64'(v), 64'h7E8);
    wr(16'h1008, 32'h0);
    rd(16'h100C, v); check("R10 lower word write ignored", 64'(v), 64'h8000_07E1);
    wr(16'h200C, 32'h0);
    check("R10 unmapped write ignored", vec_out, 64'd1 << 33);

    @(negedge clk); rst_n = 1'b0;
    #1 check("R9 reset clears request", vec_out, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(16'h100C, v); check("R9 reset clears valid", 64'(v), 64'h7E1);
    idle(3);
    check("R9 source ignored after reset", vec_out, 64'd0);

    // random phase against the reference model
    @(negedge clk); irq_in = '0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      check("R3 R8 model vec", vec_out, exp_vec());
      if ((c % 4) == 0)
        irq_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      wr_en = ($urandom % 3) == 0;
      wdata = {($urandom % 4) != 0, 31'($urandom)};
      case ($urandom % 5)
        0: addr = {8'h0C, 2'b00, 3'($urandom), 1'($urandom % 8 != 0), 2'b00};
        1: addr = {8'h10, 5'($urandom), 1'($urandom % 8 != 0), 2'b00};
        2: addr = {8'h14, 3'($urandom), 2'($urandom), 1'($urandom % 8 != 0), 2'b00};
        3: addr = {8'h18, 5'($urandom), 1'($urandom % 8 != 0), 2'b00};
        default: addr = 16'($urandom);
      endcase
      #1;
      if (!wr_en) check("R2 R10 model read", 64'(rdata), 64'(exp_rd(addr)));
    end
    @(negedge clk); wr_en = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule